// File: doc/BRIEF.md
# Tile Bitwise AND Engine

This engine combines two source tiles held in a local tile memory and stores their bitwise AND into a destination tile. A single start pulse carries the whole command. The command gives, for each of the three tiles, a byte base address, a full row length in elements (the row stride), a valid row count, a valid column count, an element type code and a layout bit. The engine visits only the destination's valid rectangle. It moves one 32-bit word per beat, so a beat carries four, two or one element for 1-, 2- or 4-byte types. Byte enables trim the final word of each row, so nothing past the valid columns is overwritten.

The command is checked in the cycle it is accepted. A bad element type, operands that disagree in type or in valid size, or a column-major operand end the command with an error flag and no memory access. Before the first access the engine can hold for a chosen subset of external event inputs. It reports completion with a one-cycle done pulse, which serves as the completion token. Fixed startup, per-beat and completion latencies are modelled, so the timing of a command follows from its size alone.

Top module: `tand_engine`

## Requirements
- R1: Every destination byte inside the valid region ends up equal to the AND of the source bytes at the same offset. Offset 0 is the tile base address, and all three tiles share the row stride used here.
- R2: The byte address of element (i, j) is base + (i × stride + j) × size. Rows are visited in order, with rows × ceil(cols × size / 4) word writes in total. When the valid row or column count is zero, no write is made.
- R3: On the last word of a row, wr_be enables only bytes 0 to n−1, where n is the number of valid bytes left in the row. Bit k of wr_be covers wr_data[8k+7:8k]. Bytes outside the valid region keep their prior value.
- R4: Type codes 0, 1 and 2 select 8-, 16- and 32-bit integers and are the only ones accepted. Any other code sets err and makes no memory access.
- R5: If a source type code differs from the destination's, or any cmd_colmaj bit is 1 (bit 0 destination, bit 1 first source, bit 2 second source), err is set and no access is made.
- R6: If a source's valid rows or valid columns differ from the destination's, err is set and no access is made.
- R7: Suppose the start is sampled at edge 0 and the awaited events are already present. Then reads begin after edge 14, and done rises after edge 31 + 2N, where N is the number of write beats.
- R8: A rejected command raises done together with err after edge 18.
- R9: The startup count advances only at edges where every wait_evt bit selected by cmd_wait_mask is 1. A mask of zero waits on nothing.
- R10: A start while busy is ignored. The running command's results, timing and err are unaffected.
- R11: After reset busy, done, err, rd_en and wr_en are 0. done is a one-cycle pulse at the edge where busy falls. err keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command request, accepted when idle |
| cmd_wait_mask | input | NEVT | Event inputs to wait for |
| cmd_typ | input | 3×3 | Element type code per tile (index 0 dst, 1 src0, 2 src1) |
| cmd_colmaj | input | 3 | Column-major flag per tile |
| cmd_base | input | 3×AW | Byte base address per tile |
| cmd_stride | input | 3×DIM_W | Full row length in elements per tile |
| cmd_vrows | input | 3×DIM_W | Valid row count per tile |
| cmd_vcols | input | 3×DIM_W | Valid column count per tile |
| wait_evt | input | NEVT | Event token levels |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion token pulse |
| err | output | 1 | Last command was rejected |
| rd_en | output | 1 | Read both sources; data returns next cycle |
| rd_addr_a | output | AW | First source word address |
| rd_addr_b | output | AW | Second source word address |
| rd_data_a | input | 32 | First source read data |
| rd_data_b | input | 32 | Second source read data |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | AW | Destination word address |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Byte enables |

## Verification
The assertions take four things for granted. The tile memory returns read data exactly one cycle after rd_en. Every base address is word aligned. Each row's stride in bytes is a multiple of four. The valid region fits inside the tile. The stimulus keeps within these limits: it places the tiles at fixed aligned bases 256 bytes apart, uses a stride of eight elements so a full row is 8, 16 or 32 bytes, and sweeps valid rows and columns from 0 to 8 for every element size. The bench drives commands only at negative edges and uses no start-pulse overlap other than the deliberate one made while busy.

// File: rtl/tand_pkg.sv
// Shared constants for the tile AND engine.
// Assumes tile index 0 is the destination, 1 and 2 the sources.
package tand_pkg;
    localparam int NTILE = 3;
    localparam int T_DST = 0;
    localparam int T_SA  = 1;
    localparam int T_SB  = 2;

    // Accepted element type codes; every other code is rejected.
    localparam logic [2:0] ET_I8  = 3'd0;
    localparam logic [2:0] ET_I16 = 3'd1;
    localparam logic [2:0] ET_I32 = 3'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_RD,
        S_WR,
        S_DRAIN,
        S_ERRH
    } state_e;
endpackage

// File: rtl/tand_cmd_check.sv
// Command validator: flags a command whose operands do not agree.
// Purely combinational; looks at the raw command inputs in the cycle
// a start is accepted. Assumes tile 0 is the destination.
module tand_cmd_check
    import tand_pkg::*;
#(
    parameter int DIM_W = 8
) (
    input  logic [NTILE-1:0][2:0]       typ,
    input  logic [NTILE-1:0]            colmaj,
    input  logic [NTILE-1:0][DIM_W-1:0] vrows,
    input  logic [NTILE-1:0][DIM_W-1:0] vcols,
    output logic                        cmd_bad
);
    logic [NTILE-1:0] same_typ;
    logic [NTILE-1:0] same_dim;
    logic             type_ok;

    // Per-tile comparison against the destination.
    for (genvar g = 0; g < NTILE; g++) begin : g_cmp
        assign same_typ[g] = (typ[g] == typ[T_DST]);
        assign same_dim[g] = (vrows[g] == vrows[T_DST]) && (vcols[g] == vcols[T_DST]);
    end

    // Only integer codes of 1, 2 or 4 bytes pass.
    assign type_ok = (typ[T_DST] == ET_I8) || (typ[T_DST] == ET_I16) ||
                     (typ[T_DST] == ET_I32);

    assign cmd_bad = !(type_ok && (&same_typ) && (&same_dim) && (colmaj == '0));
endmodule

// File: rtl/tand_addr_gen.sv
// Address walker: steps through the destination valid region one data
// word at a time, row by row, and keeps one row-base register per tile.
// Assumes word-aligned bases and row strides whose byte length is a
// multiple of DATA_BYTES.
module tand_addr_gen
    import tand_pkg::*;
#(
    parameter  int AW         = 12,
    parameter  int DIM_W      = 8,
    parameter  int DATA_BYTES = 4,
    localparam int OFF_W      = DIM_W + 3,
    localparam int NB_W       = $clog2(DATA_BYTES) + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [NTILE-1:0][AW-1:0]    base,
    input  logic [NTILE-1:0][DIM_W-1:0] stride,
    input  logic [1:0]                  lg,
    input  logic [DIM_W-1:0]            vrows,
    input  logic [DIM_W-1:0]            vcols,
    input  logic                        step,
    output logic [NTILE-1:0][AW-1:0]    addr,
    output logic [NB_W-1:0]             nbytes,
    output logic                        op_last,
    output logic                        region_empty
);
    logic [1:0]       lg_q;
    logic [DIM_W-1:0] rows_q;
    logic [DIM_W-1:0] cols_q;
    logic [DIM_W-1:0] row_cnt;
    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] row_bytes;
    logic [OFF_W-1:0] rem;
    logic             row_last;

    assign row_bytes    = OFF_W'(cols_q) << lg_q;
    assign rem          = row_bytes - off_q;
    assign row_last     = (rem <= OFF_W'(DATA_BYTES));
    assign nbytes       = row_last ? NB_W'(rem) : NB_W'(DATA_BYTES);
    assign op_last      = row_last && (row_cnt == rows_q - 1'b1);
    assign region_empty = (rows_q == '0) || (cols_q == '0);

    // Region shape capture and row/column position tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lg_q    <= '0;
            rows_q  <= '0;
            cols_q  <= '0;
            row_cnt <= '0;
            off_q   <= '0;
        end else if (load) begin
            lg_q    <= lg;
            rows_q  <= vrows;
            cols_q  <= vcols;
            row_cnt <= '0;
            off_q   <= '0;
        end else if (step) begin
            if (row_last) begin
                off_q   <= '0;
                row_cnt <= row_cnt + 1'b1;
            end else begin
                off_q <= off_q + OFF_W'(DATA_BYTES);
            end
        end
    end

    for (genvar g = 0; g < NTILE; g++) begin : g_tile
        logic [AW-1:0] rb_q;
        logic [AW-1:0] stb_q;

        // Row base of this tile, advanced by its stride in bytes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rb_q  <= '0;
                stb_q <= '0;
            end else if (load) begin
                rb_q  <= base[g];
                stb_q <= AW'(OFF_W'(stride[g]) << lg);
            end else if (step && row_last) begin
                rb_q <= rb_q + stb_q;
            end
        end

        assign addr[g] = rb_q + AW'(off_q);
    end

    AST_STEP_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (row_cnt < rows_q) && !region_empty)
        else $error("step outside region"); // R2
endmodule

// File: rtl/tand_lane.sv
// Lane unit: forms the AND word and the byte enables of one beat.
// The operation is bitwise, so element size only changes how many
// leading bytes are enabled. Assumes 1 <= nbytes <= DATA_BYTES.
module tand_lane #(
    parameter  int DATA_BYTES = 4,
    localparam int NB_W       = $clog2(DATA_BYTES) + 1
) (
    input  logic [8*DATA_BYTES-1:0] a,
    input  logic [8*DATA_BYTES-1:0] b,
    input  logic [NB_W-1:0]         nbytes,
    output logic [8*DATA_BYTES-1:0] y,
    output logic [DATA_BYTES-1:0]   be
);
    assign y = a & b;

    // One enable per byte below the valid byte count.
    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_be
        assign be[i] = (NB_W'(i) < nbytes);
    end
endmodule

// File: rtl/tand_engine.sv
// Tile AND engine top: accepts a command, validates it, waits on the
// selected events, models startup / per-beat / completion latency and
// drives the tile memory ports. Assumes a tile memory with one-cycle
// read latency and aligned tiles (see brief).
module tand_engine
    import tand_pkg::*;
#(
    parameter  int AW          = 12,
    parameter  int DIM_W       = 8,
    parameter  int NEVT        = 4,
    parameter  int DATA_BYTES  = 4,
    parameter  int STARTUP_LAT = 14,
    parameter  int COMPL_LAT   = 17,
    parameter  int ISSUE_GAP   = 18,
    localparam int DW          = 8 * DATA_BYTES,
    localparam int NB_W        = $clog2(DATA_BYTES) + 1,
    localparam int LAT_MAX     = (STARTUP_LAT > COMPL_LAT) ?
                                 ((STARTUP_LAT > ISSUE_GAP) ? STARTUP_LAT : ISSUE_GAP) :
                                 ((COMPL_LAT > ISSUE_GAP) ? COMPL_LAT : ISSUE_GAP),
    localparam int CW          = $clog2(LAT_MAX + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NEVT-1:0]             cmd_wait_mask,
    input  logic [NTILE-1:0][2:0]       cmd_typ,
    input  logic [NTILE-1:0]            cmd_colmaj,
    input  logic [NTILE-1:0][AW-1:0]    cmd_base,
    input  logic [NTILE-1:0][DIM_W-1:0] cmd_stride,
    input  logic [NTILE-1:0][DIM_W-1:0] cmd_vrows,
    input  logic [NTILE-1:0][DIM_W-1:0] cmd_vcols,
    input  logic [NEVT-1:0]             wait_evt,
    output logic                        busy,
    output logic                        done,
    output logic                        err,
    output logic                        rd_en,
    output logic [AW-1:0]               rd_addr_a,
    output logic [AW-1:0]               rd_addr_b,
    input  logic [DW-1:0]               rd_data_a,
    input  logic [DW-1:0]               rd_data_b,
    output logic                        wr_en,
    output logic [AW-1:0]               wr_addr,
    output logic [DW-1:0]               wr_data,
    output logic [DATA_BYTES-1:0]       wr_be
);
    state_e                   state;
    logic [CW-1:0]            cnt;
    logic [NEVT-1:0]          mask_q;
    logic                     cmd_bad;
    logic                     accept;
    logic                     evt_ok;
    logic [NTILE-1:0][AW-1:0] addr;
    logic [NB_W-1:0]          nbytes;
    logic                     op_last;
    logic                     region_empty;

    assign accept = start && (state == S_IDLE);
    assign evt_ok = &(wait_evt | ~mask_q);
    assign busy   = (state != S_IDLE);
    assign rd_en  = (state == S_RD);
    assign wr_en  = (state == S_WR);

    assign rd_addr_a = addr[T_SA];
    assign rd_addr_b = addr[T_SB];
    assign wr_addr   = addr[T_DST];

    tand_cmd_check #(
        .DIM_W (DIM_W)
    ) u_check (
        .typ     (cmd_typ),
        .colmaj  (cmd_colmaj),
        .vrows   (cmd_vrows),
        .vcols   (cmd_vcols),
        .cmd_bad (cmd_bad)
    );

    tand_addr_gen #(
        .AW         (AW),
        .DIM_W      (DIM_W),
        .DATA_BYTES (DATA_BYTES)
    ) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (accept),
        .base         (cmd_base),
        .stride       (cmd_stride),
        .lg           (cmd_typ[T_DST][1:0]),
        .vrows        (cmd_vrows[T_DST]),
        .vcols        (cmd_vcols[T_DST]),
        .step         (wr_en),
        .addr         (addr),
        .nbytes       (nbytes),
        .op_last      (op_last),
        .region_empty (region_empty)
    );

    tand_lane #(
        .DATA_BYTES (DATA_BYTES)
    ) u_lane (
        .a      (rd_data_a),
        .b      (rd_data_b),
        .nbytes (nbytes),
        .y      (wr_data),
        .be     (wr_be)
    );

    // Command sequencer with latency counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            mask_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        err    <= cmd_bad;
                        cnt    <= '0;
                        mask_q <= cmd_wait_mask;
                        state  <= cmd_bad ? S_ERRH : S_START;
                    end
                end
                S_START: begin
                    if (evt_ok) begin
                        if (cnt == CW'(STARTUP_LAT - 1)) begin
                            cnt   <= '0;
                            state <= region_empty ? S_DRAIN : S_RD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_RD: state <= S_WR;
                S_WR: begin
                    cnt   <= '0;
                    state <= op_last ? S_DRAIN : S_RD;
                end
                S_DRAIN: begin
                    if (cnt == CW'(COMPL_LAT - 1)) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_ERRH: begin
                    if (cnt == CW'(ISSUE_GAP - 1)) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rd_en))
        else $error("write without read"); // R2
    AST_NO_ACCESS_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && err) |-> (!rd_en && !wr_en))
        else $error("access on rejected command"); // R4
    AST_ERR_DONE_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> ($past(state) == S_ERRH))
        else $error("error completion path"); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done wider than one cycle"); // R11
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)))
        else $error("done not at end of busy"); // R11
    AST_ERR_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(err))
        else $error("err changed mid-command"); // R10
endmodule

// File: tb/test_tand_engine.sv
// Bench for the tile AND engine: sweeps every element size against
// valid rows and columns 0..8, then the rejection, event, busy-start
// and flag cases. Expected data and timing are computed here.
module test_tand_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 12;
    localparam int DIM_W = 8;
    localparam int NEVT  = 4;
    localparam int MEMSZ = 1 << AW;
    localparam int BASE_A = 'h000;
    localparam int BASE_B = 'h100;
    localparam int BASE_D = 'h200;
    localparam int STRIDE = 8;
    localparam logic [7:0] FILL = 8'hEE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NEVT-1:0] cmd_wait_mask = '0;
    logic [2:0][2:0] cmd_typ = '0;
    logic [2:0] cmd_colmaj = '0;
    logic [2:0][AW-1:0] cmd_base;
    logic [2:0][DIM_W-1:0] cmd_stride;
    logic [2:0][DIM_W-1:0] cmd_vrows = '0;
    logic [2:0][DIM_W-1:0] cmd_vcols = '0;
    logic [NEVT-1:0] wait_evt = '0;
    logic busy, done, err, rd_en, wr_en;
    logic [AW-1:0] rd_addr_a, rd_addr_b, wr_addr;
    logic [31:0] rd_data_a, rd_data_b, wr_data;
    logic [3:0] wr_be;

    logic [7:0] mem [MEMSZ];
    int total = 0;
    int bad = 0;

    assign cmd_base   = {AW'(BASE_B), AW'(BASE_A), AW'(BASE_D)};
    assign cmd_stride = {DIM_W'(STRIDE), DIM_W'(STRIDE), DIM_W'(STRIDE)};

    always #(CLK_PERIOD / 2) clk = ~clk;

    tand_engine i_tand_engine (
        .clk (clk), .rst_n (rst_n), .start (start),
        .cmd_wait_mask (cmd_wait_mask), .cmd_typ (cmd_typ),
        .cmd_colmaj (cmd_colmaj), .cmd_base (cmd_base),
        .cmd_stride (cmd_stride), .cmd_vrows (cmd_vrows),
        .cmd_vcols (cmd_vcols), .wait_evt (wait_evt),
        .busy (busy), .done (done), .err (err),
        .rd_en (rd_en), .rd_addr_a (rd_addr_a), .rd_addr_b (rd_addr_b),
        .rd_data_a (rd_data_a), .rd_data_b (rd_data_b),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data), .wr_be (wr_be)
    );

    // Tile memory model: one-cycle reads, byte-masked writes.
    always @(posedge clk) begin
        if (rd_en) begin
            for (int k = 0; k < 4; k++) begin
                rd_data_a[8*k +: 8] <= mem[(int'(rd_addr_a) + k) % MEMSZ];
                rd_data_b[8*k +: 8] <= mem[(int'(rd_addr_b) + k) % MEMSZ];
            end
        end
        if (wr_en) begin
            for (int k = 0; k < 4; k++) begin
                if (wr_be[k]) mem[(int'(wr_addr) + k) % MEMSZ] <= wr_data[8*k +: 8];
            end
        end
    end

    function automatic logic [7:0] src_a(input int o);
        return 8'(o * 7 + 3);
    endfunction
    function automatic logic [7:0] src_b(input int o);
        return 8'((o * 13) ^ 'h5A);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int a = 0; a < MEMSZ; a++) begin
            if (a < BASE_B) mem[a] = src_a(a - BASE_A);
            else if (a < BASE_D) mem[a] = src_b(a - BASE_B);
            else if (a < BASE_D + 'h100) mem[a] = FILL;
            else mem[a] = 8'h00;
        end
    endtask

    task automatic set_cmd(input int typ, input int vr, input int vc);
        for (int t = 0; t < 3; t++) begin
            cmd_typ[t]   = 3'(typ);
            cmd_vrows[t] = DIM_W'(vr);
            cmd_vcols[t] = DIM_W'(vc);
        end
        cmd_colmaj = '0;
    endtask

    // Check destination bytes: inside region AND (R1), outside FILL (R3).
    task automatic check_dst(input int lg, input int vr, input int vc);
        int es, rowb, bad_in, bad_out, ai, ei, ao, eo;
        es = 1 << lg;
        rowb = STRIDE * es;
        bad_in = 0; bad_out = 0; ai = 0; ei = 0; ao = 0; eo = 0;
        for (int o = 0; o < 'h100; o++) begin
            logic [7:0] got;
            got = mem[BASE_D + o];
            if ((o / rowb) < vr && (o % rowb) < vc * es) begin
                if (got != (src_a(o) & src_b(o))) begin
                    if (bad_in == 0) begin ai = got; ei = src_a(o) & src_b(o); end
                    bad_in++;
                end
            end else if (got != FILL) begin
                if (bad_out == 0) begin ao = got; eo = FILL; end
                bad_out++;
            end
        end
        check(bad_in == 0, "R1 in-region AND byte", ai, ei);
        check(bad_out == 0, "R3 out-of-region byte preserved", ao, eo);
    endtask

    // Issue the current command and measure it.
    task automatic do_run(input int exp_cyc, input int exp_wr, input int exp_rd,
                          input bit exp_err, input int w1, input int w2, input int poke);
        int cyc, writes, first_rd;
        init_mem();
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        if (w2 > 0) begin
            fork
                begin
                    repeat (w1) @(posedge clk);
                    @(negedge clk) wait_evt[0] = 1'b1; wait_evt[1] = 1'b1;
                    repeat (w2 - w1) @(posedge clk);
                    @(negedge clk) wait_evt[2] = 1'b1;
                end
            join_none
        end
        if (poke > 0) begin
            fork
                begin
                    logic [2:0][2:0] keep;
                    repeat (poke) @(posedge clk);
                    @(negedge clk) keep = cmd_typ; cmd_typ = '1; start = 1'b1;
                    @(negedge clk) start = 1'b0; cmd_typ = keep;
                end
            join_none
        end
        #1;
        check(err == exp_err, "R11 err updated at accepted start", int'(err), int'(exp_err));
        @(negedge clk) start = 1'b0;
        cyc = 0; writes = 0; first_rd = -1;
        while (!done && cyc < 2000) begin
            @(posedge clk);
            cyc++;
            #1;
            if (wr_en) writes++;
            if (rd_en && first_rd < 0) first_rd = cyc;
        end
        check(cyc < 2000, "R11 done reached (watchdog)", cyc, exp_cyc);
        check(cyc == exp_cyc, exp_err ? "R8 reject latency" : "R7 completion latency", cyc, exp_cyc);
        check(writes == exp_wr, "R2 write count", writes, exp_wr);
        check(first_rd == exp_rd, "R7 first read cycle", first_rd, exp_rd);
        check(err == exp_err, exp_err ? "R4 err flag on reject" : "R5 err clear on good", int'(err), int'(exp_err));
        @(negedge clk);
        wait_evt = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL R11 global watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check({busy, done, err, rd_en, wr_en} == 5'b0, "R11 reset state",
              int'({busy, done, err, rd_en, wr_en}), 0);

        // Sweep: all sizes, rows and columns 0..8 (R1 R2 R3 R7; empty R2).
        for (int lg = 0; lg < 3; lg++) begin
            for (int vr = 0; vr <= 8; vr++) begin
                for (int vc = 0; vc <= 8; vc++) begin
                    set_cmd(lg, vr, vc);
                    n = vr * (((vc << lg) + 3) / 4);
                    do_run(31 + 2 * n, n, (n > 0) ? 14 : -1, 1'b0, 0, 0, 0);
                    check_dst(lg, (n > 0) ? vr : 0, vc);
                end
            end
        end

        // R4: unsupported type codes.
        for (int c = 3; c < 8; c++) begin
            set_cmd(c, 4, 4);
            do_run(18, 0, -1, 1'b1, 0, 0, 0);
            check_dst(0, 0, 0);
        end

        // R5: source type mismatch, then layout flag on each tile.
        set_cmd(1, 4, 4); cmd_typ[1] = 3'd0;
        do_run(18, 0, -1, 1'b1, 0, 0, 0);
        set_cmd(1, 4, 4); cmd_typ[2] = 3'd2;
        do_run(18, 0, -1, 1'b1, 0, 0, 0);
        for (int t = 0; t < 3; t++) begin
            set_cmd(0, 4, 4); cmd_colmaj[t] = 1'b1;
            do_run(18, 0, -1, 1'b1, 0, 0, 0);
            check_dst(0, 0, 0);
        end

        // R6: dimension mismatch in rows, then columns.
        set_cmd(0, 4, 4); cmd_vrows[1] = 8'd3;
        do_run(18, 0, -1, 1'b1, 0, 0, 0);
        set_cmd(0, 4, 4); cmd_vcols[2] = 8'd5;
        do_run(18, 0, -1, 1'b1, 0, 0, 0);
        check_dst(0, 0, 0);

        // R11: err held while idle after a reject.
        repeat (3) @(posedge clk);
        #1;
        check(err == 1'b1, "R11 err held while idle", int'(err), 1);

        // R9: wait on events 0 and 2; event 0 alone is not enough.
        set_cmd(1, 3, 5);
        n = 3 * ((10 + 3) / 4);
        cmd_wait_mask = 4'b0101;
        do_run(31 + 2 * n + 12, n, 14 + 12, 1'b0, 4, 12, 0);
        check_dst(1, 3, 5);
        cmd_wait_mask = '0;

        // R10: start with a bad command while busy is ignored.
        set_cmd(2, 2, 3);
        n = 2 * 3;
        do_run(31 + 2 * n, n, 14, 1'b0, 0, 0, 5);
        check_dst(2, 2, 3);
        check(err == 1'b0, "R10 err unaffected by busy start", int'(err), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule